// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Activation Sequencer

This block is the control sequencer of a small transfer controller that is started by interrupts. Each activation request carries a vector number. In the normal case the sequencer makes two memory reads. The first fetches the vector address and the second fetches the transfer descriptor. It then hands the transfer to an external execution unit and waits for that unit to report completion.

When the same vector fires twice in a row and the read-skip control bit is set, the cached descriptor is reused and the transfer begins at once. This shortcut is refused whenever the previous activation ended in a chain. A descriptor in repeat mode carries a low count that decrements on every transfer and reloads from its stored high value when it reaches zero. A chain-after-repeat control bit decides whether that reload event may trigger a chained descriptor fetch.

An address error or an NMI stops the sequencer and raises a sticky error flag. While the flag is set, no new activation is accepted. Software clears the flag through a byte-wide register port, but only after it has read the flag as 1.

Top module: `xfer_act_seq`

## Requirements
- R1: After synchronous reset the register read value is 0x00, and mem_req, xfer_start, act_done and act_ack are all 0.
- R2: The register byte places read-skip enable at bit 0, chain-after-repeat enable at bit 1 and the error flag at bit 7. Bits 2 to 6 always read 0, and writing them has no effect.
- R3: act_ack is given only when the sequencer is idle and the error flag is clear. While the flag is set, a held act_req is never acknowledged.
- R4: A full fetch issues two memory reads, the first with mem_sel=0 (vector address) and the second with mem_sel=1 (descriptor). Each read holds mem_req until mem_ack, and xfer_start follows the second read.
- R5: If the vector matches the previous activation, read-skip is 1 and the previous activation had no chain, xfer_start is raised with no memory read. If read-skip is 0, the full fetch is always made.
- R6: After an activation that included a chain, the next activation makes the full fetch even when its vector matches.
- R7: The first activation after reset or after an error event makes the full fetch.
- R8: A descriptor word holds the repeat-mode flag at bit CNT_W+1, the chain flag at bit CNT_W and the count in bits CNT_W-1:0. In repeat mode each transfer decrements the low count. When the count reaches 0 it is reloaded from the loaded value, so a reload event comes every count transfers.
- R9: In normal mode, a descriptor with its chain flag set is followed by another descriptor read (mem_sel=1) and a further transfer within the same activation.
- R10: In repeat mode, a chain follows only on the transfer that causes a reload, and only if chain-after-repeat is 1.
- R11: addr_err or nmi sets the error flag. In the next cycle mem_req and xfer_start are low and the sequencer is idle.
- R12: The error flag clears only when 0 is written to bit 7 after the flag has been read as 1. Writing 1 to bit 7, or writing 0 without a prior read, leaves it set.
- R13: act_done is a single-cycle pulse at the end of each activation, after its last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_req | input | 1 | Activation request |
| act_vec | input | VEC_W | Vector number of the request |
| act_ack | output | 1 | Request accepted this cycle |
| act_done | output | 1 | End-of-activation pulse |
| mem_req | output | 1 | Memory read request |
| mem_sel | output | 1 | 0 = vector address read, 1 = descriptor read |
| mem_vec | output | VEC_W | Vector number of the current activation |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | CNT_W+2 | Descriptor word |
| xfer_start | output | 1 | Transfer execution request, held until done |
| xfer_done | input | 1 | Transfer completed |
| addr_err | input | 1 | Address error event |
| nmi | input | 1 | Non-maskable interrupt event |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |

## Verification
The bench builds the block with VEC_W=4 and CNT_W=3. A narrow vector keeps the matching and mismatching vectors easy to pick. A descriptor count of 2 puts the repeat reload on every second transfer, so both reload outcomes (with and without chaining) occur within a few activations. The small widths also keep the chain-forced refetch, the invalidation after an error and the held-off activation within a short run.

// File: rtl/xfer_act_pkg.sv
package xfer_act_pkg;

    localparam int CFG_W          = 8;
    localparam int CFG_SKIP_BIT   = 0;
    localparam int CFG_RCHAIN_BIT = 1;
    localparam int CFG_ERR_BIT    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FVEC,
        ST_FDESC,
        ST_XFER,
        ST_DONE
    } seq_state_e;

    typedef enum logic {
        SEL_VEC  = 1'b0,
        SEL_DESC = 1'b1
    } fetch_sel_e;

    typedef struct packed {
        logic skip_en;
        logic rchain_en;
        logic err;
    } cfg_t;

    // Chain decision after a completed transfer.
    function automatic logic chain_follows(logic rpt, logic chain_bit,
                                           logic reload_evt, logic rchain_en);
        return chain_bit && (!rpt || (reload_evt && rchain_en));
    endfunction

endpackage

// File: rtl/act_ctrl_regs.sv
module act_ctrl_regs
    import xfer_act_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CFG_W-1:0] reg_wdata,
    input  logic             err_evt,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] reg_rdata
);

    logic skip_q, rchain_q, err_q, armed_q;
    logic clr_ok;

    // A zero written to the flag clears it only once the set flag was read.
    assign clr_ok = reg_wr && !reg_wdata[CFG_ERR_BIT] && armed_q && err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q   <= 1'b0;
            rchain_q <= 1'b0;
            err_q    <= 1'b0;
            armed_q  <= 1'b0;
        end else begin
            if (reg_wr) begin
                skip_q   <= reg_wdata[CFG_SKIP_BIT];
                rchain_q <= reg_wdata[CFG_RCHAIN_BIT];
            end
            if (err_evt) begin
                err_q   <= 1'b1;
                armed_q <= 1'b0;
            end else if (clr_ok) begin
                err_q   <= 1'b0;
                armed_q <= 1'b0;
            end else if (reg_rd && err_q) begin
                armed_q <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata                 = '0;
        reg_rdata[CFG_SKIP_BIT]   = skip_q;
        reg_rdata[CFG_RCHAIN_BIT] = rchain_q;
        reg_rdata[CFG_ERR_BIT]    = err_q;
    end

    assign cfg = '{skip_en: skip_q, rchain_en: rchain_q, err: err_q};

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> reg_rdata[CFG_ERR_BIT]) else $error("error flag not set"); // R11

    AST_ERR_CLEAR_RULE: assert property (@(posedge clk) disable iff (rst)
        $fell(err_q) |-> ($past(reg_wr) && !$past(reg_wdata[CFG_ERR_BIT]) && $past(armed_q)))
        else $error("error flag cleared without read-then-write-0"); // R12

endmodule

// File: rtl/act_vec_track.sv
module act_vec_track #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inval,
    input  logic             upd,
    input  logic [VEC_W-1:0] upd_vec,
    input  logic             upd_chain,
    input  logic [VEC_W-1:0] cand_vec,
    input  logic             skip_en,
    output logic             skip_ok
);

    logic [VEC_W-1:0] vec_q;
    logic             valid_q;
    logic             chain_q;

    always_ff @(posedge clk) begin
        if (rst || inval) begin
            vec_q   <= '0;
            valid_q <= 1'b0;
            chain_q <= 1'b0;
        end else if (upd) begin
            vec_q   <= upd_vec;
            valid_q <= 1'b1;
            chain_q <= upd_chain;
        end
    end

    assign skip_ok = skip_en && valid_q && !chain_q && (cand_vec == vec_q);

    AST_INVAL_BLOCKS_SKIP: assert property (@(posedge clk) disable iff (rst)
        inval |=> !skip_ok) else $error("skip allowed right after invalidation"); // R7

    AST_CHAIN_FORCES_FETCH: assert property (@(posedge clk) disable iff (rst)
        (upd && upd_chain && !inval) |=> !skip_ok) else $error("skip after chain"); // R6

endmodule

// File: rtl/act_rpt_cnt.sv
module act_rpt_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_rpt,
    input  logic             step,
    output logic             rpt_mode,
    output logic             reload
);

    logic [CNT_W-1:0] lo_q, hi_q;
    logic             rpt_q;
    logic             at_last;

    assign at_last  = (lo_q <= CNT_W'(1));
    assign reload   = step && rpt_q && at_last;
    assign rpt_mode = rpt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            hi_q  <= '0;
            rpt_q <= 1'b0;
        end else if (load) begin
            lo_q  <= load_val;
            hi_q  <= load_val;
            rpt_q <= load_rpt;
        end else if (step) begin
            if (reload)
                lo_q <= hi_q;
            else if (lo_q != '0)
                lo_q <= lo_q - CNT_W'(1);
        end
    end

    AST_RELOAD_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (reload && !load) |=> (lo_q == hi_q)) else $error("reload did not restore count"); // R8

    AST_LO_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        lo_q <= hi_q) else $error("low count above reload value"); // R8

endmodule

// File: rtl/xfer_act_seq.sv
module xfer_act_seq
    import xfer_act_pkg::*;
#(
    parameter  int VEC_W  = 8,
    parameter  int CNT_W  = 8,
    localparam int DESC_W = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_req,
    input  logic [VEC_W-1:0]  act_vec,
    output logic              act_ack,
    output logic              act_done,
    output logic              mem_req,
    output logic              mem_sel,
    output logic [VEC_W-1:0]  mem_vec,
    input  logic              mem_ack,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              xfer_start,
    input  logic              xfer_done,
    input  logic              addr_err,
    input  logic              nmi,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata
);

    localparam int RPT_BIT   = CNT_W + 1;
    localparam int CHAIN_BIT = CNT_W;

    seq_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             chain_seen_q;
    logic             dchain_q;
    logic             err_evt;
    logic             skip_ok;
    logic             step;
    logic             desc_load;
    logic             reload;
    logic             rpt_mode;
    logic             chain_now;
    cfg_t             cfg;

    assign err_evt = addr_err || nmi;

    act_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .err_evt   (err_evt),
        .cfg       (cfg),
        .reg_rdata (reg_rdata)
    );

    act_vec_track #(.VEC_W(VEC_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .inval     (err_evt),
        .upd       (state_q == ST_DONE),
        .upd_vec   (vec_q),
        .upd_chain (chain_seen_q),
        .cand_vec  (act_vec),
        .skip_en   (cfg.skip_en),
        .skip_ok   (skip_ok)
    );

    act_rpt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (desc_load),
        .load_val (mem_rdata[CNT_W-1:0]),
        .load_rpt (mem_rdata[RPT_BIT]),
        .step     (step),
        .rpt_mode (rpt_mode),
        .reload   (reload)
    );

    assign act_ack    = (state_q == ST_IDLE) && act_req && !cfg.err && !err_evt;
    assign mem_req    = (state_q == ST_FVEC) || (state_q == ST_FDESC);
    assign mem_sel    = (state_q == ST_FDESC) ? SEL_DESC : SEL_VEC;
    assign mem_vec    = vec_q;
    assign xfer_start = (state_q == ST_XFER);
    assign act_done   = (state_q == ST_DONE);
    assign step       = (state_q == ST_XFER) && xfer_done && !err_evt;
    assign desc_load  = (state_q == ST_FDESC) && mem_ack && !err_evt;
    assign chain_now  = chain_follows(rpt_mode, dchain_q, reload, cfg.rchain_en);

    always_comb begin
        state_d = state_q;
        if (err_evt) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (act_ack) state_d = skip_ok ? ST_XFER : ST_FVEC;
                ST_FVEC:  if (mem_ack) state_d = ST_FDESC;
                ST_FDESC: if (mem_ack) state_d = ST_XFER;
                ST_XFER:  if (xfer_done) state_d = chain_now ? ST_FDESC : ST_DONE;
                ST_DONE:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            vec_q        <= '0;
            chain_seen_q <= 1'b0;
            dchain_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (act_ack)
                vec_q <= act_vec;
            if (desc_load)
                dchain_q <= mem_rdata[CHAIN_BIT];
            if (err_evt || act_ack)
                chain_seen_q <= 1'b0;
            else if (step && chain_now)
                chain_seen_q <= 1'b1;
        end
    end

    AST_NO_ACK_IN_ERR: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[CFG_ERR_BIT] |-> !act_ack) else $error("ack while halted"); // R3

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> (!mem_req && !xfer_start && !act_done)) else $error("not halted"); // R11

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_sel == SEL_VEC && mem_ack && !err_evt) |=> (mem_req && mem_sel == SEL_DESC))
        else $error("descriptor read does not follow vector read"); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !err_evt) |=> (mem_req && $stable(mem_sel)))
        else $error("memory request dropped before ack"); // R4

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        act_ack |=> ((mem_req && mem_sel == SEL_VEC) || xfer_start))
        else $error("accepted activation did not start"); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        act_done |=> !act_done) else $error("done longer than one cycle"); // R13

endmodule

// File: tb/xfer_act_seq_bench.sv
module xfer_act_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int B_VEC_W    = 4;
    localparam int B_CNT_W    = 3;
    localparam int B_DESC_W   = B_CNT_W + 2;

    localparam int EV_FVEC  = 1;
    localparam int EV_FDESC = 2;
    localparam int EV_XFER  = 3;
    localparam int EV_DONE  = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                act_req = 1'b0;
    logic [B_VEC_W-1:0]  act_vec = '0;
    logic                act_ack, act_done;
    logic                mem_req, mem_sel;
    logic [B_VEC_W-1:0]  mem_vec;
    logic                mem_ack = 1'b0;
    logic [B_DESC_W-1:0] mem_rdata = '0;
    logic                xfer_start;
    logic                xfer_done = 1'b0;
    logic                addr_err = 1'b0;
    logic                nmi = 1'b0;
    logic                reg_wr = 1'b0;
    logic                reg_rd = 1'b0;
    logic [7:0]          reg_wdata = '0;
    logic [7:0]          reg_rdata;

    int    n_chk = 0;
    int    n_fail = 0;
    int    done_cnt = 0;
    bit    hold_mem = 1'b0;
    bit    hold_xfer = 1'b0;
    bit    prev_done = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    logic [B_DESC_W-1:0] desc_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_act_seq #(.VEC_W(B_VEC_W), .CNT_W(B_CNT_W)) u_xfer_act_seq (
        .clk(clk), .rst(rst), .act_req(act_req), .act_vec(act_vec),
        .act_ack(act_ack), .act_done(act_done), .mem_req(mem_req),
        .mem_sel(mem_sel), .mem_vec(mem_vec), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .xfer_start(xfer_start), .xfer_done(xfer_done),
        .addr_err(addr_err), .nmi(nmi), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [B_DESC_W-1:0] mk_desc(input bit rpt, input bit ch, input int cnt);
        return {rpt, ch, B_CNT_W'(cnt)};
    endfunction

    task automatic expect_ev(input int code, input string tag);
        exp_q.push_back(code);
        tag_q.push_back(tag);
    endtask

    task automatic observe(input int code);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R4_unexpected_event", code, 0);
        end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(code == e, t, code, e);
        end
    endtask

    // Memory and transfer responders: one-cycle acknowledge after a request.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (!hold_mem && mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_sel) begin
                if (desc_q.size() > 0) mem_rdata <= desc_q.pop_front();
                else mem_rdata <= '0;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst) xfer_done <= 1'b0;
        else xfer_done <= !hold_xfer && xfer_start && !xfer_done;
    end

    // Monitor: pops expected events as the design completes handshakes.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (mem_req && mem_ack) observe(mem_sel ? EV_FDESC : EV_FVEC);
                if (xfer_start && xfer_done) observe(EV_XFER);
                if (act_done) begin
                    observe(EV_DONE);
                    done_cnt++;
                    if (prev_done) chk(1'b0, "R13_done_width", 2, 1);
                end
                prev_done = act_done;
            end
        end
    end

    task automatic reg_write(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic activate(input int vec);
        @(negedge clk);
        act_req = 1'b1;
        act_vec = B_VEC_W'(vec);
        for (int i = 0; i < 50; i++) begin
            #1;
            if (act_ack) break;
            @(negedge clk);
        end
        @(negedge clk);
        act_req = 1'b0;
    endtask

    task automatic run_act(input int vec, input string tag);
        int d0;
        d0 = done_cnt;
        activate(vec);
        for (int i = 0; i < 100; i++) begin
            if (done_cnt > d0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk(done_cnt == d0 + 1, tag, done_cnt - d0, 1);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic exp_full(input string tag);
        expect_ev(EV_FVEC, tag);
        expect_ev(EV_FDESC, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(reg_rdata == 8'h00, "R1_rdata", reg_rdata, 0);
        chk(!mem_req && !xfer_start && !act_done && !act_ack, "R1_outputs",
            {mem_req, xfer_start, act_done, act_ack}, 0);

        // R2: reserved bits read 0, writing 1 to the error bit is ignored (R12)
        reg_write(8'hFF);
        reg_read(rv);
        chk(rv == 8'h03, "R2_R12_layout", rv, 8'h03);
        reg_write(8'h01);

        // R7 and R4: first activation after reset makes the full fetch
        desc_q.push_back(mk_desc(0, 0, 3));
        exp_full("R7_first_fetch");
        expect_ev(EV_XFER, "R4_xfer_after_fetch");
        expect_ev(EV_DONE, "R13_done");
        run_act(5, "R7_R4_act");

        // R5: same vector, skip enabled
        expect_ev(EV_XFER, "R5_skip_xfer");
        expect_ev(EV_DONE, "R13_done");
        run_act(5, "R5_skip_act");

        // R9: new vector, normal-mode chain
        desc_q.push_back(mk_desc(0, 1, 2));
        desc_q.push_back(mk_desc(0, 0, 1));
        exp_full("R9_fetch");
        expect_ev(EV_XFER, "R9_first_xfer");
        expect_ev(EV_FDESC, "R9_chain_desc");
        expect_ev(EV_XFER, "R9_chain_xfer");
        expect_ev(EV_DONE, "R13_done");
        run_act(6, "R9_chain_act");

        // R6: previous activation chained, so full fetch again
        desc_q.push_back(mk_desc(0, 0, 1));
        exp_full("R6_refetch");
        expect_ev(EV_XFER, "R6_xfer");
        expect_ev(EV_DONE, "R13_done");
        run_act(6, "R6_act");

        expect_ev(EV_XFER, "R5_skip_again");
        expect_ev(EV_DONE, "R13_done");
        run_act(6, "R5_skip_again_act");

        // R5: skip disabled means full fetch; load repeat descriptor count 2
        reg_write(8'h00);
        desc_q.push_back(mk_desc(1, 1, 2));
        exp_full("R5_noskip_fetch");
        expect_ev(EV_XFER, "R8_rpt_xfer1");
        expect_ev(EV_DONE, "R13_done");
        run_act(6, "R5_noskip_act");

        // R10 and R8: reload with chain-after-repeat off gives no chain
        reg_write(8'h01);
        expect_ev(EV_XFER, "R8_rpt_xfer2");
        expect_ev(EV_DONE, "R10_no_chain_on_reload");
        run_act(6, "R10_off_act");

        expect_ev(EV_XFER, "R8_after_reload");
        expect_ev(EV_DONE, "R8_no_reload_yet");
        run_act(6, "R8_mid_act");

        // R10: reload with chain-after-repeat on chains
        reg_write(8'h03);
        desc_q.push_back(mk_desc(0, 0, 1));
        expect_ev(EV_XFER, "R8_reload_xfer");
        expect_ev(EV_FDESC, "R10_chain_on_reload");
        expect_ev(EV_XFER, "R10_chain_xfer");
        expect_ev(EV_DONE, "R13_done");
        run_act(6, "R10_on_act");

        desc_q.push_back(mk_desc(0, 0, 1));
        exp_full("R6_refetch_after_rpt_chain");
        expect_ev(EV_XFER, "R6_xfer2");
        expect_ev(EV_DONE, "R13_done");
        run_act(6, "R6_act2");

        // R11: NMI during a stalled fetch
        hold_mem = 1'b1;
        activate(7);
        @(negedge clk);
        chk(mem_req == 1'b1, "R4_req_held", mem_req, 1);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        #1;
        chk(mem_req == 1'b0 && xfer_start == 1'b0, "R11_halt_nmi", mem_req, 0);

        // R3: held request not acknowledged while the flag is set
        act_req = 1'b1;
        act_vec = 4'd6;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1;
            chk(act_ack == 1'b0, "R3_no_ack_in_error", act_ack, 0);
        end
        act_req = 1'b0;

        // R12: write 0 without a read leaves the flag set
        reg_write(8'h03);
        reg_read(rv);
        chk(rv == 8'h83, "R12_no_clear_without_read", rv, 8'h83);
        reg_write(8'h83);
        reg_read(rv);
        chk(rv == 8'h83, "R12_write1_no_effect", rv, 8'h83);
        reg_write(8'h03);
        reg_read(rv);
        chk(rv == 8'h03, "R12_cleared", rv, 8'h03);
        hold_mem = 1'b0;

        // R7: first activation after the error makes the full fetch
        desc_q.push_back(mk_desc(0, 0, 1));
        exp_full("R7_after_error");
        expect_ev(EV_XFER, "R7_xfer");
        expect_ev(EV_DONE, "R13_done");
        run_act(6, "R7_err_act");

        // R11: address error during a transfer that was started by skip (R5)
        hold_xfer = 1'b1;
        activate(6);
        #1;
        chk(xfer_start == 1'b1 && mem_req == 1'b0, "R5_skip_direct_start", xfer_start, 1);
        @(negedge clk);
        addr_err = 1'b1;
        @(negedge clk);
        addr_err = 1'b0;
        #1;
        chk(xfer_start == 1'b0, "R11_halt_addr_err", xfer_start, 0);
        reg_read(rv);
        chk(rv == 8'h83, "R11_flag_set", rv, 8'h83);
        reg_write(8'h03);
        reg_read(rv);
        chk(rv == 8'h03, "R12_clear_again", rv, 8'h03);
        hold_xfer = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R13_no_stray_events", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule